// File: doc/BRIEF.md
# Mersenne Product Reduction Normaliser

This unit accepts a carry-free product polynomial whose coefficients are signed 32-bit words at digit weight 2^13 (2·NDIG−1 of them, 191 by default) and returns the product reduced modulo N = 2^M − 1. The result comes out as NDIG signed 13-bit digits. It sits after a digit-level multiplier in a modular arithmetic pipeline. The multiplier's schoolbook or Karatsuba sums arrive unnormalised, and this block turns them back into the same signed-digit form the multiplier consumes.

On a start pulse the block first adds a bias to every coefficient. The bias makes each word non-negative, and its total telescopes to zero modulo N, so no correction constant is needed at the end. The block also adds the usual half-radix digit offset to the low words. It then folds each upper coefficient down, one per cycle. Each upper word is split into two 16-bit halves, and each half is shifted by its own amount and added to its own low word. The shift and position come from constant tables that are computed at elaboration from M. Finally it runs a serial carry pass over the low words. Any carry that leaves the top digit is re-entered at the position congruent to 2^(13·NDIG) modulo N, and propagation resumes from there until no carry remains. Each output digit is its normalised word minus 2^12.

Top module: `mersenne_reduce_norm`

## Requirements
- R1: After reset, busy_o and done_o are 0 and every output digit reads 0.
- R2: A start_i pulse while the block is idle (busy_o = 0 and done_o = 0) latches coef_i, and busy_o is 1 in the next cycle.
- R3: done_o is high for exactly one cycle, busy_o falls in that same cycle, and done_o rises no sooner than (NDIG−1)+NDIG cycles after the start edge and no later than that plus 3·(NDIG+1).
- R4: Digit k of dig_o occupies bits [13k+12:13k] in two's complement with weight 2^(13k). The sum of these digits times their weights is congruent modulo 2^M − 1 to the sum over j of coef_i word j (bits [32j+31:32j], signed) times 2^(13j).
- R5: R4 holds at the coefficient extremes reached by products of two NDIG-digit signed 13-bit polynomials (all digits −4096 squared, and −4096 times +4095), and no internal word overflows.
- R6: start_i and coef_i are ignored while busy_o is 1: the result equals the one for the coefficients latched at the accepted start.
- R7: Once done_o has pulsed, dig_o holds its value for as long as start_i stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a reduction; honoured only when idle |
| coef_i | input | (2·NDIG−1)·32 | Product coefficients, word j signed at weight 2^(13j) |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle pulse: dig_o holds the new result |
| dig_o | output | NDIG·13 | Reduced signed 13-bit digits, digit 0 lowest |

## Verification
busy_o is due one cycle after the accepted start edge. The fold stage takes exactly NDIG−1 cycles and the first carry pass NDIG cycles. Each top-carry re-entry then adds one cycle plus the length of the resumed pass, so done_o has a fixed earliest cycle and a bounded latest one. The bench drives and samples on falling edges and counts cycles from the start edge until done_o. It checks that the count lies in that window, that done_o is low again one cycle later, and only then compares the digits, modulo 2^M − 1, against a wide-integer product computed from the digit polynomials the coefficients were built from. Three configurations (two small ones and the full-size one) are swept with structured and pseudo-random operands.

// File: rtl/mrn_pkg.sv
package mrn_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FOLD,
      ST_CARRY,
      ST_WRAP,
      ST_DONE
   } mrn_state_e;

   // Exponent of a power of two after reduction by 2^modulus == 1.
   function automatic int wrap_exp(input int weight, input int modulus);
      return weight % modulus;
   endfunction

endpackage

// File: rtl/mrn_bias.sv
// Adds the telescoping non-negativity bias and the low-digit offset to each
// incoming coefficient, and flags any word whose biased value is out of range.
module mrn_bias #(
   parameter int NDIG = 96,
   parameter int D    = 13,
   parameter int CW   = 32,
   parameter int ACCW = 40,
   parameter int M    = 1193,
   localparam int NC  = 2*NDIG-1,
   localparam int NUP = NC-NDIG
) (
   input  logic [NC*CW-1:0] coef_i,
   output logic [ACCW-1:0]  low_o [NDIG],
   output logic [CW-1:0]    up_o  [NUP],
   output logic [NC-1:0]    flt_o
);

   localparam int GAMMA = D*NC + (CW-1-D) - M;
   localparam int BETA  = GAMMA / D;
   localparam int ALPHA = GAMMA % D;

   for (genvar j = 0; j < NC; j++) begin : g_co
      localparam longint TOPB = longint'(1) <<< (CW-1);
      localparam longint STEP = (j == 0) ? TOPB : (TOPB - (longint'(1) <<< (CW-1-D)));
      localparam longint FIX  = (j == BETA) ? (longint'(1) <<< ALPHA) : longint'(0);
      localparam longint OFS  = (j < NDIG) ? (longint'(1) <<< (D-1)) : longint'(0);
      localparam longint BV   = STEP - FIX + OFS;
      logic signed [ACCW:0] sum;
      assign sum = (ACCW+1)'(signed'(coef_i[j*CW +: CW])) + (ACCW+1)'(BV);
      if (j < NDIG) begin : g_low
         assign low_o[j] = sum[ACCW-1:0];
         assign flt_o[j] = sum[ACCW];
      end else begin : g_up
         assign up_o[j-NDIG] = sum[CW-1:0];
         assign flt_o[j]     = |sum[ACCW:CW];
      end
   end

endmodule

// File: rtl/mrn_fold_rom.sv
// Elaboration-time tables giving, for each upper coefficient, the target low
// digit and left shift of its lower and upper halves.
module mrn_fold_rom
   import mrn_pkg::*;
#(
   parameter int NDIG = 96,
   parameter int D    = 13,
   parameter int CW   = 32,
   parameter int M    = 1193,
   parameter int CNTW = 8,
   parameter int PW   = 7,
   parameter int SW   = 4
) (
   input  logic [CNTW-1:0] idx_i,
   output logic [PW-1:0]   pos_lo_o,
   output logic [PW-1:0]   pos_hi_o,
   output logic [SW-1:0]   sh_lo_o,
   output logic [SW-1:0]   sh_hi_o
);

   localparam int NUP = NDIG-1;
   localparam int HW  = CW/2;

   logic [PW-1:0] t_pl [NUP];
   logic [PW-1:0] t_ph [NUP];
   logic [SW-1:0] t_sl [NUP];
   logic [SW-1:0] t_sh [NUP];

   for (genvar i = 0; i < NUP; i++) begin : g_tab
      localparam int ELO = wrap_exp(D*(i+NDIG), M);
      localparam int EHI = wrap_exp(D*(i+NDIG) + HW, M);
      assign t_pl[i] = PW'(ELO / D);
      assign t_sl[i] = SW'(ELO % D);
      assign t_ph[i] = PW'(EHI / D);
      assign t_sh[i] = SW'(EHI % D);
   end

   always_comb begin
      pos_lo_o = '0;
      pos_hi_o = '0;
      sh_lo_o  = '0;
      sh_hi_o  = '0;
      for (int i = 0; i < NUP; i++) begin
         if (idx_i == CNTW'(i)) begin
            pos_lo_o = t_pl[i];
            pos_hi_o = t_ph[i];
            sh_lo_o  = t_sl[i];
            sh_hi_o  = t_sh[i];
         end
      end
   end

endmodule

// File: rtl/mersenne_reduce_norm.sv
// Reduces a carry-free 13-bit-radix product modulo 2^M - 1 and normalises it
// into signed 13-bit digits: bias, serial fold-down, serial carry with wrap.
module mersenne_reduce_norm
   import mrn_pkg::*;
#(
   parameter int NDIG  = 96,
   parameter int D     = 13,
   parameter int CW    = 32,
   parameter int M     = 1193,
   parameter int GUARD = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [(2*NDIG-1)*CW-1:0]  coef_i,
   output logic                      busy_o,
   output logic                      done_o,
   output logic [NDIG*D-1:0]         dig_o
);

   localparam int NC      = 2*NDIG-1;
   localparam int NUP     = NC-NDIG;
   localparam int ACCW    = CW + GUARD;
   localparam int HW      = CW/2;
   localparam int CNTW    = $clog2(NC);
   localparam int PW      = $clog2(NDIG);
   localparam int SW      = $clog2(D);
   localparam int GW      = D*NDIG - M;
   localparam int BETA_W  = GW / D;
   localparam int ALPHA_W = GW % D;
   localparam logic [ACCW-1:0] DBIAS = ACCW'(1) << (D-1);
   localparam logic [D-1:0]    DBD   = D'(1) << (D-1);

   initial begin
      assert (M >= CW && M <= D*NDIG - 2)
         else $error("modulus exponent out of range for digit count");
      assert (CW % 2 == 0 && HW + D - 1 < ACCW - 1)
         else $error("coefficient width unsuitable for half folding");
      assert (longint'(NDIG) * (longint'(1) <<< (2*D-2)) + (longint'(1) <<< D)
              < (longint'(1) <<< (CW-1)) - (longint'(1) <<< (CW-1-D)))
         else $error("coefficient bound exceeds bias headroom");
   end

   mrn_state_e    st_q, st_d;
   logic [CNTW-1:0] cnt_q, cnt_d;
   logic [ACCW-1:0] tau_q, tau_d;
   logic [ACCW-1:0] w_q [NDIG];
   logic [ACCW-1:0] w_d [NDIG];
   logic [CW-1:0]   up_q [NUP];

   logic [ACCW-1:0] low_b [NDIG];
   logic [CW-1:0]   up_b  [NUP];
   logic [NC-1:0]   flt_b;

   logic [PW-1:0] pos_lo, pos_hi;
   logic [SW-1:0] sh_lo, sh_hi;
   logic [CW-1:0]   ucur;
   logic [ACCW-1:0] wsel, csum, add_lo, add_hi;
   logic            accept;

   mrn_bias #(.NDIG(NDIG), .D(D), .CW(CW), .ACCW(ACCW), .M(M)) u_bias (
      .coef_i (coef_i),
      .low_o  (low_b),
      .up_o   (up_b),
      .flt_o  (flt_b)
   );

   mrn_fold_rom #(.NDIG(NDIG), .D(D), .CW(CW), .M(M), .CNTW(CNTW),
                  .PW(PW), .SW(SW)) u_rom (
      .idx_i    (cnt_q),
      .pos_lo_o (pos_lo),
      .pos_hi_o (pos_hi),
      .sh_lo_o  (sh_lo),
      .sh_hi_o  (sh_hi)
   );

   assign accept = (st_q == ST_IDLE) && start_i;

   // operand selection for the current fold and carry step
   always_comb begin
      ucur = '0;
      for (int i = 0; i < NUP; i++) begin
         if (cnt_q == CNTW'(i)) ucur = up_q[i];
      end
      wsel = '0;
      for (int k = 0; k < NDIG; k++) begin
         if (cnt_q == CNTW'(k)) wsel = w_q[k];
      end
   end

   assign add_lo = ACCW'(ucur[HW-1:0]) << sh_lo;
   assign add_hi = ACCW'(ucur[CW-1:HW]) << sh_hi;
   assign csum   = tau_q + wsel;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      tau_d = tau_q;
      for (int k = 0; k < NDIG; k++) w_d[k] = w_q[k];
      case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               st_d  = ST_FOLD;
               cnt_d = '0;
               tau_d = '0;
            end
         end
         ST_FOLD: begin
            for (int k = 0; k < NDIG; k++) begin
               w_d[k] = w_q[k]
                      + ((pos_lo == PW'(k)) ? add_lo : '0)
                      + ((pos_hi == PW'(k)) ? add_hi : '0);
            end
            if (cnt_q == CNTW'(NUP-1)) begin
               st_d  = ST_CARRY;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_CARRY: begin
            for (int k = 0; k < NDIG; k++) begin
               if (cnt_q == CNTW'(k)) w_d[k] = ACCW'(csum[D-1:0]);
            end
            tau_d = csum >> D;
            if (cnt_q == CNTW'(NDIG-1)) begin
               st_d = (tau_d != '0) ? ST_WRAP : ST_DONE;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_WRAP: begin
            w_d[BETA_W] = w_q[BETA_W] + (tau_q << ALPHA_W);
            tau_d = '0;
            cnt_d = CNTW'(BETA_W);
            st_d  = ST_CARRY;
         end
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         tau_q <= '0;
         for (int k = 0; k < NDIG; k++) w_q[k] <= DBIAS;
         for (int i = 0; i < NUP; i++) up_q[i] <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         tau_q <= tau_d;
         if (accept) begin
            for (int k = 0; k < NDIG; k++) w_q[k] <= low_b[k];
            for (int i = 0; i < NUP; i++) up_q[i] <= up_b[i];
         end else begin
            for (int k = 0; k < NDIG; k++) w_q[k] <= w_d[k];
         end
      end
   end

   assign busy_o = (st_q == ST_FOLD) || (st_q == ST_CARRY) || (st_q == ST_WRAP);
   assign done_o = (st_q == ST_DONE);

   for (genvar k = 0; k < NDIG; k++) begin : g_out
      assign dig_o[k*D +: D] = w_q[k][D-1:0] - DBD;
   end

   logic ovf;
   always_comb begin
      ovf = 1'b0;
      for (int k = 0; k < NDIG; k++) ovf = ovf | w_q[k][ACCW-1];
   end

   a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !done_o && start_i) |=> busy_o);

   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r3_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf);

   a_r5_bias_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !done_o && start_i) |-> (flt_b == '0));

   a_r6_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(up_q[NUP-1]));

   a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(dig_o));

endmodule

// File: tb/sim_mersenne_reduce_norm.sv
module mrn_lane_tb #(
   parameter int NDIG = 8,
   parameter int M    = 61,
   parameter int SEED = 1
) (
   input  logic clk,
   input  logic rst_n,
   output int   n_chk,
   output int   n_fail,
   output logic fin
);
   localparam int D    = 13;
   localparam int CW   = 32;
   localparam int NC   = 2*NDIG-1;
   localparam int NUP  = NDIG-1;
   localparam int BW   = 2*D*NDIG + 64;
   localparam int LMIN = NUP + NDIG;
   localparam int LMAX = LMIN + 3*(NDIG+1);
   localparam logic [BW-1:0] MASK = (BW'(1) << M) - BW'(1);
   localparam logic [BW-1:0] OFF  = MASK << (D*NDIG - M + 1);

   logic              start;
   logic [NC*CW-1:0]  coef;
   logic              busy, done;
   logic [NDIG*D-1:0] dig;

   mersenne_reduce_norm #(.NDIG(NDIG), .M(M)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .coef_i(coef),
      .busy_o(busy), .done_o(done), .dig_o(dig)
   );

   int a [NDIG];
   int b [NDIG];
   int dg [NDIG];
   int unsigned rs;

   task automatic chk(input bit ok, input string msg);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL M=%0d %s", M, msg);
      end
   endtask

   function automatic logic [BW-1:0] modn(input logic [BW-1:0] xin);
      logic [BW-1:0] x = xin;
      while (x > MASK) x = (x & MASK) + (x >> M);
      if (x == MASK) x = '0;
      return x;
   endfunction

   function automatic logic [BW-1:0] to_big(input int d [NDIG]);
      logic [BW-1:0] v = '0;
      for (int i = NDIG-1; i >= 0; i--)
         v = (v << D) + {{(BW-32){d[i][31]}}, d[i]};
      return modn(v + OFF);
   endfunction

   function automatic int rnd_dig();
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      return int'(rs[12:0]) - 4096;
   endfunction

   task automatic gen(input int pat);
      for (int i = 0; i < NDIG; i++) begin
         case (pat)
            0: begin a[i] = 0;     b[i] = 0;     end
            1: begin a[i] = -4096; b[i] = -4096; end
            2: begin a[i] = -4096; b[i] = 4095;  end
            3: begin a[i] = 4095;  b[i] = 4095;  end
            4: begin a[i] = (i%2 == 0) ? 4095 : -4096; b[i] = (i%3 == 0) ? -1 : 1; end
            5: begin a[i] = (i == NDIG-1) ? 4095 : 0; b[i] = (i == NDIG-1) ? -4096 : 0; end
            default: begin a[i] = rnd_dig(); b[i] = rnd_dig(); end
         endcase
      end
   endtask

   task automatic build_coef();
      for (int j = 0; j < NC; j++) begin
         int s = 0;
         for (int i = 0; i < NDIG; i++)
            if (j-i >= 0 && j-i < NDIG) s += a[i] * b[j-i];
         coef[j*CW +: CW] = s;
      end
   endtask

   task automatic run_one(input string req, input bit restart);
      logic [BW-1:0] expv, gotv;
      logic [NDIG*D-1:0] held;
      int cyc;
      build_coef();
      expv = modn(to_big(a) * to_big(b));
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, $sformatf("R2 busy after start act=%0b exp=1", busy));
      cyc = 0;
      while (!done && cyc < 3000) begin
         if (restart && cyc == 5) begin start = 1'b1; coef = ~coef; end
         if (restart && cyc == 6) start = 1'b0;
         @(negedge clk);
         cyc++;
      end
      chk(cyc >= LMIN && cyc <= LMAX,
          $sformatf("R3 latency act=%0d exp=%0d..%0d", cyc, LMIN, LMAX));
      for (int k = 0; k < NDIG; k++) dg[k] = int'($signed(dig[k*D +: D]));
      gotv = to_big(dg);
      chk(gotv == expv, $sformatf("%s residue act=%h exp=%h", req, gotv, expv));
      held = dig;
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0,
          $sformatf("R3 single done act=%0b%0b exp=00", done, busy));
      repeat (3) @(negedge clk);
      chk(dig == held, $sformatf("R7 hold act=%h exp=%h", dig, held));
   endtask

   initial begin
      n_chk = 0;
      n_fail = 0;
      fin = 1'b0;
      start = 1'b0;
      coef = '0;
      rs = 32'h9E3779B9 ^ SEED;
      @(posedge rst_n);
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && dig == '0,
          $sformatf("R1 reset busy=%0b done=%0b dig=%h exp=0,0,0", busy, done, dig));
      gen(0); run_one("R4 zero", 1'b0);
      gen(1); run_one("R5 max positive", 1'b0);
      gen(2); run_one("R5 max negative", 1'b0);
      gen(3); run_one("R5 high positive", 1'b0);
      gen(4); run_one("R4 alternating", 1'b0);
      gen(5); run_one("R4 top coefficient", 1'b0);
      gen(6); run_one("R6 restart ignored", 1'b1);
      for (int t = 0; t < 14; t++) begin
         gen(6);
         run_one("R4 random", 1'b0);
      end
      fin = 1'b1;
   end
endmodule

module sim_mersenne_reduce_norm;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int c0, f0, c1, f1, c2, f2;
   logic d0, d1, d2;
   bit reported = 1'b0;

   mrn_lane_tb #(.NDIG(8),  .M(61),   .SEED(3)) l0 (.clk(clk), .rst_n(rst_n), .n_chk(c0), .n_fail(f0), .fin(d0));
   mrn_lane_tb #(.NDIG(8),  .M(101),  .SEED(7)) l1 (.clk(clk), .rst_n(rst_n), .n_chk(c1), .n_fail(f1), .fin(d1));
   mrn_lane_tb #(.NDIG(96), .M(1193), .SEED(11)) l2 (.clk(clk), .rst_n(rst_n), .n_chk(c2), .n_fail(f2), .fin(d2));

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   end

   initial begin
      wait (d0 && d1 && d2);
      if (!reported) begin
         reported = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", c0+c1+c2, f0+f1+f2);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!reported) begin
         reported = 1'b1;
         $display("FAIL watchdog act=timeout exp=all lanes finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", c0+c1+c2+1, f0+f1+f2+1);
         $finish;
      end
   end
endmodule